// File: doc/BRIEF.md
# Group-Bypass Carry Adder

This block adds two unsigned (or two's-complement) operands plus a single carry bit and produces the full-width sum together with the carry leaving the most significant position. It is purely combinational and is intended to sit inside a datapath stage where the worst-case carry path sets the cycle time.

The operand is cut into equal slices. Inside each slice the carry ripples bit by bit through full-adder cells. Each slice also forms the exclusive-OR of every operand bit pair. When every pair in the slice differs, the slice can only pass its incoming carry through, so a two-way selector hands the incoming carry straight to the next slice and skips the internal ripple. When any pair in the slice is equal, that pair either creates or absorbs the carry, and the slice's outgoing carry comes from its ripple chain. In that case the outgoing carry no longer depends on the incoming one. The per-slice bypass decisions are brought out as a debug vector.

Top module: `skip_carry_adder`

## Requirements
- R1: `sum_out` equals the low `GROUP_W*N_GROUPS` bits of `a_in + b_in + c_in` for every input combination.
- R2: `c_out` equals the bit above the top of the sum, i.e. bit `GROUP_W*N_GROUPS` of `a_in + b_in + c_in`.
- R3: Bit g of `grp_skip` covers operand bits `g*GROUP_W` up to `g*GROUP_W+GROUP_W-1`. It is 1 exactly when `a_in` and `b_in` differ in every one of those bits.
- R4: When every slice bypasses (`a_in ^ b_in` all ones), the carry travels straight through: `c_out` equals `c_in`, and `sum_out` is all ones for `c_in`=0 and all zeros for `c_in`=1.
- R5: When the top slice does not bypass, `c_out` does not depend on `c_in`. It equals the `a_in` bit at the highest position in the top slice where `a_in` and `b_in` agree.
- R6: With 4-bit slices, 0101+1010 with `c_in`=1 in slice 0 sets `grp_skip[0]` and gives 0x10. 0101+1110 clears `grp_skip[0]` and gives 0x13.
- R7: Slices are chained: carries cross every slice boundary, so all-ones plus zero with `c_in`=1 gives a zero sum and `c_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | GROUP_W*N_GROUPS | First operand |
| b_in | input | GROUP_W*N_GROUPS | Second operand |
| c_in | input | 1 | Incoming carry at bit 0 |
| sum_out | output | GROUP_W*N_GROUPS | Sum bits |
| c_out | output | 1 | Carry out of the top bit |
| grp_skip | output | N_GROUPS | Per-slice bypass decision, bit g for slice g |

## Verification
The bench builds the adder with its defaults: four slices of four bits. This makes the 4-bit slice examples, a mix of bypassing and rippling slices, and carries that cross all three slice boundaries reachable with small hand-checked vectors. Random operands with both carry-in values exercise the bypass selector in every slice. Carry-in toggling on operands whose top slice does not bypass shows that the outgoing carry is independent of the carry-in.

// File: rtl/cska_pkg.sv
package cska_pkg;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x | y));
  endfunction

  function automatic logic bit_prop(input logic x, input logic y);
    return x ^ y;
  endfunction

endpackage

// File: rtl/cska_bit_cell.sv
module cska_bit_cell
  import cska_pkg::*;
(
  input  logic op_a,
  input  logic op_b,
  input  logic cy_i,
  output logic sum_o,
  output logic cy_o,
  output logic prop_o
);
  assign sum_o  = fa_sum(op_a, op_b, cy_i);
  assign cy_o   = fa_carry(op_a, op_b, cy_i);
  assign prop_o = bit_prop(op_a, op_b);
endmodule

// File: rtl/cska_skip_mux.sv
module cska_skip_mux (
  input  logic sel_bypass,
  input  logic bypass_cy,
  input  logic ripple_cy,
  output logic cy_o
);
  always_comb begin
    if (sel_bypass) cy_o = bypass_cy;
    else            cy_o = ripple_cy;
  end
endmodule

// File: rtl/cska_group.sv
module cska_group #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a_grp,
  input  logic [GROUP_W-1:0] b_grp,
  input  logic               cy_in,
  output logic [GROUP_W-1:0] sum_grp,
  output logic               cy_out,
  output logic               skip_o
);
  logic [GROUP_W:0]   ripple;
  logic [GROUP_W-1:0] prop;

  assign ripple[0] = cy_in;

  for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
    cska_bit_cell u_cell (
      .op_a   (a_grp[i]),
      .op_b   (b_grp[i]),
      .cy_i   (ripple[i]),
      .sum_o  (sum_grp[i]),
      .cy_o   (ripple[i+1]),
      .prop_o (prop[i])
    );
  end

  // all-propagate detector
  assign skip_o = &prop;

  cska_skip_mux u_mux (
    .sel_bypass (skip_o),
    .bypass_cy  (cy_in),
    .ripple_cy  (ripple[GROUP_W]),
    .cy_o       (cy_out)
  );
endmodule

// File: rtl/skip_carry_adder.sv
module skip_carry_adder #(
  parameter int GROUP_W  = 4,
  parameter int N_GROUPS = 4,
  localparam int WIDTH   = GROUP_W * N_GROUPS
) (
  input  logic [WIDTH-1:0]    a_in,
  input  logic [WIDTH-1:0]    b_in,
  input  logic                c_in,
  output logic [WIDTH-1:0]    sum_out,
  output logic                c_out,
  output logic [N_GROUPS-1:0] grp_skip
);
  logic [N_GROUPS:0] grp_cy;

  assign grp_cy[0] = c_in;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    cska_group #(.GROUP_W(GROUP_W)) u_grp (
      .a_grp   (a_in[g*GROUP_W +: GROUP_W]),
      .b_grp   (b_in[g*GROUP_W +: GROUP_W]),
      .cy_in   (grp_cy[g]),
      .sum_grp (sum_out[g*GROUP_W +: GROUP_W]),
      .cy_out  (grp_cy[g+1]),
      .skip_o  (grp_skip[g])
    );
  end

  assign c_out = grp_cy[N_GROUPS];
endmodule

// File: rtl/cska_checker.sv
module cska_checker #(
  parameter int GROUP_W  = 4,
  parameter int N_GROUPS = 4,
  localparam int WIDTH   = GROUP_W * N_GROUPS
) (
  input logic [WIDTH-1:0]    a_in,
  input logic [WIDTH-1:0]    b_in,
  input logic                c_in,
  input logic [WIDTH-1:0]    sum_out,
  input logic                c_out,
  input logic [N_GROUPS-1:0] grp_skip
);
  logic [WIDTH:0]        ref_total;
  logic [N_GROUPS-1:0]   ref_skip;
  logic                  top_found;
  logic                  top_gen;

  always_comb begin
    ref_total = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};
    for (int g = 0; g < N_GROUPS; g++) begin
      ref_skip[g] = ((a_in[g*GROUP_W +: GROUP_W] ^ b_in[g*GROUP_W +: GROUP_W])
                     == {GROUP_W{1'b1}});
    end
    top_found = 1'b0;
    top_gen   = 1'b0;
    for (int i = WIDTH - 1; i >= WIDTH - GROUP_W; i--) begin
      if (!top_found && (a_in[i] == b_in[i])) begin
        top_found = 1'b1;
        top_gen   = a_in[i];
      end
    end
  end

  always_comb begin
    a_r1_sum: assert (sum_out == ref_total[WIDTH-1:0])
      else $error("R1 sum mismatch");
    a_r2_carry: assert (c_out == ref_total[WIDTH])
      else $error("R2 carry mismatch");
    a_r3_skip: assert (grp_skip == ref_skip)
      else $error("R3 skip mismatch");
    a_r4_bypass: assert (!(&grp_skip) || (c_out == c_in))
      else $error("R4 bypass carry mismatch");
    a_r5_indep: assert (grp_skip[N_GROUPS-1] || (c_out == top_gen))
      else $error("R5 top slice carry mismatch");
  end
endmodule

bind skip_carry_adder cska_checker #(.GROUP_W(GROUP_W), .N_GROUPS(N_GROUPS)) u_chk (
  .a_in     (a_in),
  .b_in     (b_in),
  .c_in     (c_in),
  .sum_out  (sum_out),
  .c_out    (c_out),
  .grp_skip (grp_skip)
);

// File: tb/sim_skip_carry_adder.sv
module sim_skip_carry_adder;
  localparam int GW = 4;
  localparam int NG = 4;
  localparam int W  = GW * NG;
  localparam int NV = 8;

  // {a, b, cin, expected {cout,sum}, expected skip}
  localparam logic [53:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000, 4'b0000},
    {16'hFFFF, 16'h0001, 1'b0, 17'h10000, 4'b1110},
    {16'h5555, 16'hAAAA, 1'b1, 17'h10000, 4'b1111},
    {16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF, 4'b1111},
    {16'h1234, 16'h4321, 1'b0, 17'h05555, 4'b0000},
    {16'h8000, 16'h8000, 1'b0, 17'h10000, 4'b0000},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, 4'b0000},
    {16'h0F0F, 16'hF0F1, 1'b0, 17'h10000, 4'b1110}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [NG-1:0] sk;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  skip_carry_adder #(.GROUP_W(GW), .N_GROUPS(NG)) u0 (
    .a_in(a), .b_in(b), .c_in(ci), .sum_out(s), .c_out(co), .grp_skip(sk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
  endtask

  function automatic logic [NG-1:0] exp_skip(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) begin
      r[g] = 1'b1;
      for (int i = 0; i < GW; i++) if (x[g*GW+i] == y[g*GW+i]) r[g] = 1'b0;
    end
    return r;
  endfunction

  initial begin
    logic c0;
    a = '0; b = '0; ci = 1'b0;
    // idle state with zero inputs
    apply('0, '0, 1'b0);
    chk("R1 idle sum", 32'(s), 32'h0);
    chk("R2 idle carry", 32'(co), 32'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][53:38], VEC[v][37:22], VEC[v][21]);
      chk("R1 table sum", 32'(s), 32'(VEC[v][19:4]));
      chk("R2 table carry", 32'(co), 32'(VEC[v][20]));
      chk("R3 table skip", 32'(sk), 32'(VEC[v][3:0]));
    end

    // R4 all slices bypass
    apply(16'h3C96, 16'hC369, 1'b1);
    chk("R4 bypass carry", 32'(co), 32'h1);
    chk("R4 bypass sum", 32'(s), 32'h0);
    apply(16'h3C96, 16'hC369, 1'b0);
    chk("R4 bypass carry0", 32'(co), 32'h0);
    chk("R4 bypass sum0", 32'(s), 32'hFFFF);

    // R5 top slice not bypassing: carry-out independent of carry-in
    apply(16'h9FFF, 16'h6001 ^ 16'h1000, 1'b0);
    c0 = co;
    apply(16'h9FFF, 16'h6001 ^ 16'h1000, 1'b1);
    chk("R5 cin toggle", 32'(co), 32'(c0));
    chk("R5 generated carry", 32'(co), 32'h1);
    apply(16'h2000, 16'hCFFF, 1'b1);
    chk("R5 killed carry", 32'(co), 32'h0);

    // R6 slice examples
    apply(16'h0005, 16'h000A, 1'b1);
    chk("R6 skip taken", 32'(sk[0]), 32'h1);
    chk("R6 sum 0x10", 32'(s), 32'h0010);
    apply(16'h0005, 16'h000E, 1'b0);
    chk("R6 skip not taken", 32'(sk[0]), 32'h0);
    chk("R6 sum 0x13", 32'(s), 32'h0013);

    // R7 carry crosses all slices
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R7 chain sum", 32'(s), 32'h0);
    chk("R7 chain carry", 32'(co), 32'h1);
    chk("R7 chain skip", 32'(sk), 32'hF);

    // random and all-propagate mixes
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] x, y;
      logic [W:0]   t;
      logic         c;
      x = W'($urandom);
      y = (n % 3 == 0) ? ~x ^ W'($urandom & 32'h0F0F) : W'($urandom);
      c = n[0];
      apply(x, y, c);
      t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
      chk("R1 random sum", 32'(s), 32'(t[W-1:0]));
      chk("R2 random carry", 32'(co), 32'(t[W]));
      chk("R3 random skip", 32'(sk), 32'(exp_skip(x, y)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule